// File: doc/BRIEF.md
# Multi-Error ECC Correction Sequencer

This block is the back end of a NAND error-correction path that can repair up to four bad bytes in a 512-byte chunk. Software, or an upstream controller, first loads the eight 10-bit check words that were stored with the chunk through a single write port. The words appear on a flat output bus for the syndrome and location engine. When the chunk has been read into the local data buffer, a start pulse hands the sequencer the four syndrome words. If none of the meaningful syndrome bits is set, the sequencer finishes at once with nothing to repair.

With a non-zero syndrome the sequencer clears the engine's stale location result, launches the location calculation, and then watches the engine's status word. Right after launch the engine's state field shows a misleading "ready" code. The sequencer ignores every status word until the field has shown a busy code (4 or above) or a wait counter has run out. It then acts on the result: no error, uncorrectable, or a count of one to four entries. Each entry holds a 10-bit raw location and an 8-bit error mask, packed two per 32-bit word. The raw location is mirrored into a byte offset, and every offset that falls inside the data area is fixed by a read-modify-write of the buffer. A host port on the second side of the buffer fills it before a run and reads the repaired bytes afterwards.

Top module: `ecc_corr_seq`

## Requirements
- R1: The k-th write on the check-word port (k = 0 first) lands in slot 7-k of `chk_vec`, with slot s at bits s*10+9 : s*10. `chk_loaded` rises after the write to slot 0. The next write starts again at slot 7 and drops `chk_loaded`.
- R2: At start, only bits 9:0 and 25:16 of each 32-bit syndrome word count (word w sits at bits w*32+31 : w*32). When all of those bits are zero, `done` pulses in the cycle after start with `fixed_cnt` = 0, and neither `loc_clr` nor `loc_go` is raised.
- R3: With a non-zero syndrome, `loc_clr` pulses for one cycle and `loc_go` pulses in the following cycle.
- R4: The engine state is `eng_status` bits 11:8. After `loc_go`, a state of 2 or 3 is acted on only once a state of 4 or more has been seen, or after WAIT_CYC cycles of waiting.
- R5: A state of 0 ends the run with `fixed_cnt` = 0 and `uncorrectable` low. A state of 1 ends it with `uncorrectable` high, `fixed_cnt` = 0 and the buffer unchanged.
- R6: On state 2 or 3, the entry count is 1 plus `eng_status` bits 17:16.
- R7: Entries 0 and 1 come from `loc_pair0`/`mag_pair0`, and entries 2 and 3 from `loc_pair1`/`mag_pair1`. Even entries use bits 15:0 of the word and odd entries bits 31:16. The location is the low 10 bits of that half and the mask is the low 8 bits.
- R8: The byte offset is 519 minus the raw location. Only offsets 0..511 (raw 8..519) are applied; any other raw value is skipped.
- R9: Each applied entry XORs its mask into the buffer byte at its offset, entries in index order, and `fixed_cnt` counts the applied entries.
- R10: `done` is a one-cycle pulse. `fixed_cnt` and `uncorrectable` hold their values from `done` until the next start.
- R11: A host write updates the buffer byte at `host_addr`, and a host read returns that byte on `host_rdata` one cycle after the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_wr | input | 1 | Check-word write strobe |
| chk_wdata | input | 10 | Check word to store |
| chk_vec | output | 80 | Eight stored check words, slot s at bits s*10+9 : s*10 |
| chk_loaded | output | 1 | All eight slots written |
| start | input | 1 | Begin a correction run |
| syn_words | input | 128 | Four syndrome words |
| eng_status | input | 32 | Engine status: state in bits 11:8, count-1 in bits 17:16 |
| loc_pair0 | input | 32 | Raw locations of entries 0 (low) and 1 (high) |
| loc_pair1 | input | 32 | Raw locations of entries 2 (low) and 3 (high) |
| mag_pair0 | input | 32 | Error masks of entries 0 (low) and 1 (high) |
| mag_pair1 | input | 32 | Error masks of entries 2 (low) and 3 (high) |
| loc_clr | output | 1 | Pulse clearing the engine's stale location result |
| loc_go | output | 1 | Pulse launching the location calculation |
| host_we | input | 1 | Host buffer write enable |
| host_addr | input | 9 | Host buffer byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, one cycle latency |
| done | output | 1 | Run finished, one cycle |
| uncorrectable | output | 1 | Last run found too many errors |
| fixed_cnt | output | 3 | Bytes repaired in the last run |

## Verification
The assertions assume that the host port stays quiet while a run is in progress. They also assume that the syndrome words and the four entry words hold steady from start until `done`. The engine status is taken as coherent: it may show the misleading code 3 right after launch, and it must eventually settle on a final state. The bench keeps to this by touching the buffer only between runs. Its engine stub presents a changing status sequence: early code 3 with a wrong count, then a busy code, then the final word. For the timeout case the stub stays at code 3 throughout.

// File: rtl/ecc_corr_pkg.sv
package ecc_corr_pkg;

  localparam int CHUNK_BYTES = 512;
  localparam int LOC_BIAS    = CHUNK_BYTES + 7;
  localparam int LOC_W       = 10;
  localparam int MAG_W       = 8;
  localparam int SYN_WORDS   = 4;
  localparam logic [31:0] SYN_MASK = 32'h03FF_03FF;

  typedef struct packed {
    logic       hit;
    logic [8:0] off;
  } boff_t;

  function automatic logic syn_live(input logic [SYN_WORDS*32-1:0] s);
    logic acc;
    acc = 1'b0;
    for (int w = 0; w < SYN_WORDS; w++) acc = acc | (|(s[w*32 +: 32] & SYN_MASK));
    return acc;
  endfunction

  function automatic logic [3:0] st_field(input logic [31:0] status);
    return status[11:8];
  endfunction

  function automatic logic [1:0] cnt_field(input logic [31:0] status);
    return status[17:16];
  endfunction

  function automatic logic [15:0] half_pick(input logic [1:0] idx,
                                            input logic [31:0] w0,
                                            input logic [31:0] w1);
    logic [31:0] w;
    w = idx[1] ? w1 : w0;
    return idx[0] ? w[31:16] : w[15:0];
  endfunction

  function automatic logic [LOC_W-1:0] entry_loc(input logic [1:0] idx,
                                                 input logic [31:0] p0,
                                                 input logic [31:0] p1);
    logic [15:0] h;
    h = half_pick(idx, p0, p1);
    return h[LOC_W-1:0];
  endfunction

  function automatic logic [MAG_W-1:0] entry_mag(input logic [1:0] idx,
                                                 input logic [31:0] p0,
                                                 input logic [31:0] p1);
    logic [15:0] h;
    h = half_pick(idx, p0, p1);
    return h[MAG_W-1:0];
  endfunction

  function automatic boff_t byte_off(input logic [LOC_W-1:0] raw);
    boff_t r;
    logic [LOC_W-1:0] d;
    d     = LOC_W'(LOC_BIAS) - raw;
    r.hit = (raw >= LOC_W'(LOC_BIAS - CHUNK_BYTES + 1)) && (raw <= LOC_W'(LOC_BIAS));
    r.off = d[8:0];
    return r;
  endfunction

endpackage

// File: rtl/ecc_chk_store.sv
module ecc_chk_store #(
  parameter int CHK_N = 8,
  parameter int CHK_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [CHK_W-1:0]   wdata,
  output logic [CHK_N*CHK_W-1:0] vec,
  output logic               loaded
);
  localparam int PTR_W = (CHK_N > 1) ? $clog2(CHK_N) : 1;
  localparam logic [PTR_W-1:0] TOP_SLOT = PTR_W'(CHK_N - 1);

  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= TOP_SLOT;
      loaded <= 1'b0;
    end else if (wr) begin
      if (ptr == '0) begin
        ptr    <= TOP_SLOT;
        loaded <= 1'b1;
      end else begin
        ptr    <= ptr - 1'b1;
        loaded <= 1'b0;
      end
    end
  end

  for (genvar s = 0; s < CHK_N; s++) begin : g_slot
    logic [CHK_W-1:0] slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         slot_q <= '0;
      else if (wr && ptr == PTR_W'(s))    slot_q <= wdata;
    end
    assign vec[s*CHK_W +: CHK_W] = slot_q;
  end
endmodule

// File: rtl/ecc_fix_ram.sv
module ecc_fix_ram #(
  parameter int DEPTH = 512,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     a_we,
  input  logic [$clog2(DEPTH)-1:0] a_addr,
  input  logic [DW-1:0]            a_wdata,
  output logic [DW-1:0]            a_rdata,
  input  logic                     b_we,
  input  logic [$clog2(DEPTH)-1:0] b_addr,
  input  logic [DW-1:0]            b_wdata,
  output logic [DW-1:0]            b_rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/ecc_fix_fsm.sv
module ecc_fix_fsm
  import ecc_corr_pkg::*;
#(
  parameter int WAIT_CYC = 25000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [SYN_WORDS*32-1:0] syn_words,
  input  logic [31:0]            eng_status,
  input  logic [31:0]            loc_pair0,
  input  logic [31:0]            loc_pair1,
  input  logic [31:0]            mag_pair0,
  input  logic [31:0]            mag_pair1,
  output logic                   loc_clr,
  output logic                   loc_go,
  output logic                   seq_we,
  output logic [8:0]             seq_addr,
  output logic [MAG_W-1:0]       seq_wdata,
  input  logic [MAG_W-1:0]       seq_rdata,
  output logic                   done,
  output logic                   uncorrectable,
  output logic [2:0]             fixed_cnt,
  output logic                   busy,
  output logic                   hold_exit,
  output logic                   timer_exp
);
  localparam int TMR_W = (WAIT_CYC > 2) ? $clog2(WAIT_CYC) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WAIT_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CLR, S_GO, S_HOLD, S_POLL, S_PICK, S_WR, S_DONE
  } st_t;

  st_t              st;
  logic [TMR_W-1:0] tmr;
  logic [1:0]       idx, last_idx;
  logic [8:0]       off_q;
  logic [MAG_W-1:0] mag_q;
  logic [3:0]       eng_st;
  boff_t            pick;
  logic             at_last;

  assign eng_st    = st_field(eng_status);
  assign pick      = byte_off(entry_loc(idx, loc_pair0, loc_pair1));
  assign at_last   = (idx == last_idx);
  assign timer_exp = (st == S_HOLD) && (tmr == TMR_LAST);
  assign hold_exit = (st == S_HOLD) && ((eng_st >= 4'd4) || timer_exp);

  assign busy      = (st != S_IDLE);
  assign loc_clr   = (st == S_CLR);
  assign loc_go    = (st == S_GO);
  assign done      = (st == S_DONE);
  assign seq_we    = (st == S_WR);
  assign seq_addr  = (st == S_WR) ? off_q : pick.off;
  assign seq_wdata = seq_rdata ^ mag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      tmr           <= '0;
      idx           <= '0;
      last_idx      <= '0;
      off_q         <= '0;
      mag_q         <= '0;
      fixed_cnt     <= '0;
      uncorrectable <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          fixed_cnt     <= '0;
          uncorrectable <= 1'b0;
          st            <= syn_live(syn_words) ? S_CLR : S_DONE;
        end
        S_CLR: st <= S_GO;
        S_GO: begin
          tmr <= '0;
          st  <= S_HOLD;
        end
        S_HOLD: begin
          tmr <= tmr + 1'b1;
          if (hold_exit) st <= S_POLL;
        end
        S_POLL: begin
          case (eng_st)
            4'd0: st <= S_DONE;
            4'd1: begin
              uncorrectable <= 1'b1;
              st            <= S_DONE;
            end
            4'd2, 4'd3: begin
              last_idx <= cnt_field(eng_status);
              idx      <= '0;
              st       <= S_PICK;
            end
            default: st <= S_POLL;
          endcase
        end
        S_PICK: begin
          if (pick.hit) begin
            off_q <= pick.off;
            mag_q <= entry_mag(idx, mag_pair0, mag_pair1);
            st    <= S_WR;
          end else if (at_last) begin
            st <= S_DONE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_WR: begin
          fixed_cnt <= fixed_cnt + 1'b1;
          if (at_last) st <= S_DONE;
          else begin
            idx <= idx + 1'b1;
            st  <= S_PICK;
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecc_corr_seq.sv
module ecc_corr_seq
  import ecc_corr_pkg::*;
#(
  parameter int CHK_N    = 8,
  parameter int CHK_W    = 10,
  parameter int WAIT_CYC = 25000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chk_wr,
  input  logic [CHK_W-1:0]   chk_wdata,
  output logic [CHK_N*CHK_W-1:0] chk_vec,
  output logic               chk_loaded,
  input  logic               start,
  input  logic [SYN_WORDS*32-1:0] syn_words,
  input  logic [31:0]        eng_status,
  input  logic [31:0]        loc_pair0,
  input  logic [31:0]        loc_pair1,
  input  logic [31:0]        mag_pair0,
  input  logic [31:0]        mag_pair1,
  output logic               loc_clr,
  output logic               loc_go,
  input  logic               host_we,
  input  logic [8:0]         host_addr,
  input  logic [MAG_W-1:0]   host_wdata,
  output logic [MAG_W-1:0]   host_rdata,
  output logic               done,
  output logic               uncorrectable,
  output logic [2:0]         fixed_cnt
);
  logic             seq_we;
  logic [8:0]       seq_addr;
  logic [MAG_W-1:0] seq_wdata, seq_rdata;
  logic             busy, hold_exit, timer_exp;

  ecc_chk_store #(.CHK_N(CHK_N), .CHK_W(CHK_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(chk_wr), .wdata(chk_wdata),
    .vec(chk_vec), .loaded(chk_loaded)
  );

  ecc_fix_ram #(.DEPTH(CHUNK_BYTES), .DW(MAG_W)) u_buf (
    .clk(clk),
    .a_we(seq_we), .a_addr(seq_addr), .a_wdata(seq_wdata), .a_rdata(seq_rdata),
    .b_we(host_we), .b_addr(host_addr), .b_wdata(host_wdata), .b_rdata(host_rdata)
  );

  ecc_fix_fsm #(.WAIT_CYC(WAIT_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .syn_words(syn_words),
    .eng_status(eng_status), .loc_pair0(loc_pair0), .loc_pair1(loc_pair1),
    .mag_pair0(mag_pair0), .mag_pair1(mag_pair1),
    .loc_clr(loc_clr), .loc_go(loc_go),
    .seq_we(seq_we), .seq_addr(seq_addr), .seq_wdata(seq_wdata), .seq_rdata(seq_rdata),
    .done(done), .uncorrectable(uncorrectable), .fixed_cnt(fixed_cnt),
    .busy(busy), .hold_exit(hold_exit), .timer_exp(timer_exp)
  );
endmodule

// File: rtl/ecc_corr_seq_chk.sv
module ecc_corr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        chk_wr,
  input logic        chk_loaded,
  input logic [31:0] eng_status,
  input logic        loc_clr,
  input logic        loc_go,
  input logic        done,
  input logic        uncorrectable,
  input logic [2:0]  fixed_cnt,
  input logic        seq_we,
  input logic        busy,
  input logic        hold_exit,
  input logic        timer_exp
);
  p_reload_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_wr && chk_loaded |=> !chk_loaded);

  p_clr_then_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loc_clr |=> loc_go);

  p_go_after_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    loc_go |-> $past(loc_clr));

  p_early_exit_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_exit && !timer_exp |-> eng_status[11:8] >= 4'd4);

  p_unc_no_fix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uncorrectable |-> fixed_cnt == 3'd0);

  p_fix_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fixed_cnt <= 3'd4);

  p_write_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_we |-> busy);

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(fixed_cnt) && $stable(uncorrectable));
endmodule

bind ecc_corr_seq ecc_corr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .chk_wr(chk_wr), .chk_loaded(chk_loaded),
  .eng_status(eng_status), .loc_clr(loc_clr), .loc_go(loc_go), .done(done),
  .uncorrectable(uncorrectable), .fixed_cnt(fixed_cnt), .seq_we(seq_we),
  .busy(busy), .hold_exit(hold_exit), .timer_exp(timer_exp)
);

// File: tb/ecc_corr_seq_bench.sv
module ecc_corr_seq_bench;
  localparam int NV = 10;

  typedef struct packed {
    logic [1:0]  syn_mode;
    logic [3:0]  fin_st;
    logic [1:0]  cnt_bits;
    logic        slow;
    logic [31:0] l0, l1, m0, m1;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd2, 2'd0, 1'b0, 32'h0000_0207, 32'h0, 32'h0000_005A, 32'h0},
    '{2'd1, 4'd2, 2'd0, 1'b0, 32'h0000_0207, 32'h0, 32'h0000_00FF, 32'h0},
    '{2'd2, 4'd2, 2'd0, 1'b0, 32'h0000_0207, 32'h0, 32'h0000_005A, 32'h0},
    '{2'd2, 4'd3, 2'd1, 1'b0, 32'h0008_0064, 32'h0, 32'h0081_003C, 32'h0},
    '{2'd2, 4'd2, 2'd3, 1'b0, 32'h012D_012C, 32'h0207_012E, 32'h0022_0011, 32'h0044_0033},
    '{2'd2, 4'd2, 2'd2, 1'b0, 32'h0007_0208, 32'hFFFF_FCC8, 32'h0099_0088, 32'h0000_0077},
    '{2'd2, 4'd1, 2'd0, 1'b0, 32'h0000_0100, 32'h0, 32'h0000_00FF, 32'h0},
    '{2'd2, 4'd0, 2'd0, 1'b0, 32'h0000_0100, 32'h0, 32'h0000_00FF, 32'h0},
    '{2'd2, 4'd3, 2'd0, 1'b1, 32'h0000_0077, 32'h0, 32'h0000_00A5, 32'h0},
    '{2'd2, 4'd2, 2'd1, 1'b0, 32'h012C_012C, 32'h0, 32'h00F0_000F, 32'h0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         chk_wr = 1'b0;
  logic [9:0]   chk_wdata = '0;
  logic [79:0]  chk_vec;
  logic         chk_loaded;
  logic         start = 1'b0;
  logic [127:0] syn_words = '0;
  logic [31:0]  eng_status = '0;
  logic [31:0]  loc_pair0 = '0, loc_pair1 = '0, mag_pair0 = '0, mag_pair1 = '0;
  logic         loc_clr, loc_go;
  logic         host_we = 1'b0;
  logic [8:0]   host_addr = '0;
  logic [7:0]   host_wdata = '0;
  logic [7:0]   host_rdata;
  logic         done, uncorrectable;
  logic [2:0]   fixed_cnt;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [512];

  always #2 clk = ~clk;

  ecc_corr_seq #(.WAIT_CYC(64)) u_ecc_corr_seq (
    .clk(clk), .rst_n(rst_n), .chk_wr(chk_wr), .chk_wdata(chk_wdata),
    .chk_vec(chk_vec), .chk_loaded(chk_loaded), .start(start), .syn_words(syn_words),
    .eng_status(eng_status), .loc_pair0(loc_pair0), .loc_pair1(loc_pair1),
    .mag_pair0(mag_pair0), .mag_pair1(mag_pair1), .loc_clr(loc_clr), .loc_go(loc_go),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .done(done), .uncorrectable(uncorrectable),
    .fixed_cnt(fixed_cnt)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_word(input logic [3:0] s, input logic [1:0] c);
    return {14'h0, c, 4'h0, s, 8'hA5};
  endfunction

  task automatic host_write(input int a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = 9'(a); host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_read(input int a, output logic [7:0] d);
    @(negedge clk);
    host_addr = 9'(a);
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic compare_buffer(input string tag);
    int bad = 0;
    int first_a = -1;
    logic [7:0] d, first_d;
    first_d = '0;
    for (int a = 0; a < 512; a++) begin
      host_read(a, d);
      if (d !== model[a]) begin
        if (bad == 0) begin first_a = a; first_d = d; end
        bad++;
      end
    end
    if (first_a < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, tag, int'(first_d), int'(model[first_a]));
  endtask

  task automatic run_vec(input int n);
    vec_t v;
    int exp_cnt, clr_at, go_at, k, cyc, nent;
    bit got, exp_unc;
    logic [2:0] got_cnt;
    logic got_unc;
    v = VECS[n];
    syn_words = '0;
    if (v.syn_mode == 2'd1) begin
      syn_words[31:0]   = 32'hFC00_FC00;
      syn_words[127:96] = 32'h8000_0400;
    end else if (v.syn_mode == 2'd2) begin
      syn_words[95:64] = 32'h0001_0000;
    end
    loc_pair0 = v.l0; loc_pair1 = v.l1; mag_pair0 = v.m0; mag_pair1 = v.m1;
    eng_status = '0;
    exp_cnt = 0;
    exp_unc = (v.syn_mode == 2'd2) && (v.fin_st == 4'd1);
    if (v.syn_mode == 2'd2 && (v.fin_st == 4'd2 || v.fin_st == 4'd3)) begin
      nent = int'(v.cnt_bits) + 1;
      for (int e = 0; e < nent; e++) begin
        int word, raw, off, msk;
        word = (e < 2) ? int'(v.l0) : int'(v.l1);
        msk  = (e < 2) ? int'(v.m0) : int'(v.m1);
        if (e % 2 == 1) begin word = word >>> 16; msk = msk >>> 16; end
        raw = word & 'h3FF;
        off = 519 - raw;
        if (off >= 0 && off < 512) begin
          model[off] = model[off] ^ 8'(msk & 'hFF);
          exp_cnt++;
        end
      end
    end
    @(negedge clk);
    start = 1'b1;
    clr_at = -1; go_at = -1; k = -1; cyc = 0; got = 0;
    got_cnt = '0; got_unc = 1'b0;
    while (!got && cyc < 600) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (loc_clr) clr_at = cyc;
      if (loc_go) begin go_at = cyc; k = 0; end
      if (k >= 0) begin
        if (v.slow)        eng_status = stat_word(4'd3, v.cnt_bits);
        else if (k < 4)    eng_status = stat_word(4'd3, 2'd0);
        else if (k < 10)   eng_status = stat_word(4'd6, 2'd0);
        else               eng_status = stat_word(v.fin_st, v.cnt_bits);
        k++;
      end
      if (done) begin got = 1; got_cnt = fixed_cnt; got_unc = uncorrectable; end
    end
    check(got, $sformatf("R10 vec%0d done seen", n), int'(got), 1);
    if (v.syn_mode != 2'd2) begin
      check(clr_at < 0 && go_at < 0, $sformatf("R2 vec%0d no engine launch", n), go_at, -1);
      check(cyc == 1, $sformatf("R2 vec%0d done latency", n), cyc, 1);
    end else begin
      check(clr_at > 0 && go_at == clr_at + 1, $sformatf("R3 vec%0d clr then go", n), go_at, clr_at + 1);
    end
    check(got_cnt == 3'(exp_cnt), $sformatf("R4 R6 R7 R8 R9 vec%0d fixed count", n), int'(got_cnt), exp_cnt);
    check(got_unc == exp_unc, $sformatf("R5 vec%0d uncorrectable", n), int'(got_unc), int'(exp_unc));
    @(negedge clk);
    check(!done && fixed_cnt == got_cnt && uncorrectable == got_unc,
          $sformatf("R10 vec%0d pulse and hold", n), int'(fixed_cnt), int'(got_cnt));
    compare_buffer($sformatf("R8 R9 vec%0d buffer", n));
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check(!done && !uncorrectable && fixed_cnt == 3'd0 && !loc_clr && !loc_go && !chk_loaded,
          "reset state", int'(fixed_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !chk_loaded && chk_vec == '0, "reset state after release", int'(chk_loaded), 0);

    // R1: descending slot order
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      chk_wr = 1'b1; chk_wdata = 10'(10'h100 + w * 3);
      @(negedge clk);
      chk_wr = 1'b0;
      if (w == 6) check(!chk_loaded, "R1 not loaded after seven", int'(chk_loaded), 0);
    end
    check(chk_loaded, "R1 loaded after eight", int'(chk_loaded), 1);
    for (int w = 0; w < 8; w++)
      check(chk_vec[(7 - w) * 10 +: 10] == 10'(10'h100 + w * 3), "R1 slot content",
            int'(chk_vec[(7 - w) * 10 +: 10]), 10'h100 + w * 3);
    @(negedge clk);
    chk_wr = 1'b1; chk_wdata = 10'h3FF;
    @(negedge clk);
    chk_wr = 1'b0;
    check(!chk_loaded && chk_vec[79:70] == 10'h3FF && chk_vec[9:0] == 10'h115,
          "R1 restart at slot 7", int'(chk_vec[79:70]), 10'h3FF);

    // R11: host port write then read
    for (int a = 0; a < 512; a++) begin
      model[a] = 8'((a * 37 + 11) & 'hFF);
      host_write(a, model[a]);
    end
    host_read(300, d);
    check(d == model[300], "R11 host read back", int'(d), int'(model[300]));
    host_read(511, d);
    check(d == model[511], "R11 host read top byte", int'(d), int'(model[511]));

    for (int n = 0; n < NV; n++) run_vec(n);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule